// File: doc/BRIEF.md
# NAND Flash Command-Phase Sequencer

This block drives a raw 8-bit NAND flash bus from a small register set. Software loads column, row and data registers, an address-size setting and a packed timing word. It then writes one control word. That word names the bus phases to run, and each phase is either enabled or skipped: an opening command byte, column address bytes, row address bytes, a closing command byte (followed by a wait for the device's ready/busy line), and a data transfer of one to four bytes in either direction. The block runs the enabled phases in that fixed order, then clears the start flag. Software polls that flag.

Chip-enable can be held low from one control word to the next. A longer NAND transaction, such as a page read built from several word-sized data reads, can therefore be split across several control words. Every strobe edge is timed in clock cycles taken from five 6-bit fields. Bytes read from the device are packed into the 32-bit data register. A ready/busy wait that runs past a fixed limit raises an error flag.

Top module: `nand_cmd_engine`

## Requirements
- R1: Register map at `host_addr` values: 0 control, 1 column, 2 row, 3 data, 4 address config, 5 timing. Writing the control register with bit 31 set starts an operation. Bit 31 reads back 1 until the operation finishes and then reads 0. While bit 31 is 1, all host writes are ignored.
- R2: The enabled phases run in this fixed order: opening command, column, row, closing command, data. The enables are bit 16 (opening command), bit 17 (column), bit 18 (row), bit 19 (closing command), bit 21 (data write) and bit 20 (data read). The opening opcode is bits 7:0 and the closing opcode is bits 15:8.
- R3: The column phase sends config bits 5:4 plus one bytes of the column register, least significant byte first. The row phase sends config bits 7:6 plus one bytes of the row register in the same order.
- R4: When control bit 24 is set, exactly one address byte is sent: column register bits 7:0. It replaces both the column phase and the row phase.
- R5: A data write sends control bits 29:28 plus one bytes of the data register, least significant byte first. If bits 21 and 20 are both set, the write is done and the read is not.
- R6: A data read packs the bytes received into the data register, little-endian. Byte k lands in bits 8k+7:8k. Bytes beyond the count read as 0.
- R7: CE# is low for the whole operation. When the operation ends, CE# stays low if control bit 30 was set and goes high if it was clear.
- R8: Each WE#/RE# low pulse lasts timing bits 5:0 cycles. The strobe high phase lasts bits 23:18 plus bits 11:6 cycles. CLE, ALE and the driven data are set up for bits 17:12 cycles before the strobe falls. A field value of 0 counts as 1.
- R9: After the closing command, the block waits timing bits 29:24 cycles (0 counts as 1). It then waits for R/B# to go high before the data phase. Control read bit 26 shows R/B# delayed by a two-flop synchronizer.
- R10: If R/B# stays low for TIMEOUT cycles of that wait, the block sets control bit 27, skips the data phase and ends the operation. The next start clears bit 27.
- R11: CLE is high only around command bytes, and ALE only around address bytes. Bus bytes are driven (dq_oe high) before WE# falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on host_addr) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus byte driven to the device |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus byte from the device |
| nand_rb_n | input | 1 | Device ready (high) / busy (low) |

## Verification
A wrong phase state shows up at once on the bus: a byte is latched with the wrong CLE/ALE qualifier or in the wrong order, and the bench's byte log catches it on that WE# edge. A wrong byte index or count shows up as a wrong length or wrong value in the log, or as misplaced bytes in the data register when the start flag clears. Timer faults show up as a wrong WE#/RE# low-cycle count within one byte. Ready-wait and hold faults show up in the error bit, the read count and CE# right after completion.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int TW = 6;

  localparam int B_START = 31;
  localparam int B_HOLD  = 30;
  localparam int B_ERR   = 27;
  localparam int B_RDY   = 26;
  localparam int B_SPEC  = 24;
  localparam int B_WR    = 21;
  localparam int B_RD    = 20;
  localparam int B_CMD1  = 19;
  localparam int B_ROW   = 18;
  localparam int B_COL   = 17;
  localparam int B_CMD0  = 16;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD0, PH_COL, PH_ROW, PH_CMD1, PH_WAIT, PH_POLL, PH_DATA, PH_END
  } phase_t;

  typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_WR, BK_RD} kind_t;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_LOW, ST_HOLD, ST_GAP} strobe_t;

  function automatic logic [TW-1:0] eff_cycles(input logic [TW-1:0] f);
    return (f == '0) ? TW'(1) : f;
  endfunction

  function automatic logic phase_on(input phase_t p, input logic [31:0] c);
    case (p)
      PH_CMD0: return c[B_CMD0];
      PH_COL:  return c[B_COL] | c[B_SPEC];
      PH_ROW:  return c[B_ROW] & ~c[B_SPEC];
      PH_CMD1, PH_WAIT, PH_POLL: return c[B_CMD1];
      PH_DATA: return c[B_WR] | c[B_RD];
      PH_END:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic phase_t phase_after(input phase_t p, input logic [31:0] c);
    phase_t r;
    r = PH_END;
    for (int i = int'(PH_END); i > int'(p); i--) begin
      if (phase_on(phase_t'(i), c)) r = phase_t'(i);
    end
    return r;
  endfunction

  function automatic logic [1:0] phase_last(input phase_t p, input logic [31:0] c,
                                            input logic [7:0] cfg);
    case (p)
      PH_COL:  return c[B_SPEC] ? 2'd0 : cfg[5:4];
      PH_ROW:  return cfg[7:6];
      PH_DATA: return c[29:28];
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] i);
    return w[8*i +: 8];
  endfunction
endpackage

// File: rtl/nfc_strobe.sv
module nfc_strobe
  import nfc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  kind_t         kind,
  input  logic [7:0]    byte_in,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_low,
  input  logic [TW-1:0] t_hold,
  input  logic [TW-1:0] t_gap,
  input  logic [7:0]    dq_i,
  output logic          idle,
  output logic          done,
  output logic          rd_valid,
  output logic [7:0]    rd_byte,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    dq_o,
  output logic          dq_oe
);
  strobe_t       st;
  logic [TW-1:0] cnt;
  kind_t         kind_q;
  logic [7:0]    byte_q;
  logic          active;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign active   = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HOLD);
  assign idle     = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      kind_q   <= BK_CMD;
      byte_q   <= '0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          kind_q <= kind;
          byte_q <= byte_in;
          st     <= ST_SETUP;
          cnt    <= eff_cycles(t_setup) - TW'(1);
        end
        ST_SETUP: if (cnt_zero) begin
          st  <= ST_LOW;
          cnt <= eff_cycles(t_low) - TW'(1);
        end else cnt <= cnt - TW'(1);
        ST_LOW: if (cnt_zero) begin
          st  <= ST_HOLD;
          cnt <= eff_cycles(t_hold) - TW'(1);
          if (kind_q == BK_RD) begin
            rd_byte  <= dq_i;
            rd_valid <= 1'b1;
          end
        end else cnt <= cnt - TW'(1);
        ST_HOLD: if (cnt_zero) begin
          st  <= ST_GAP;
          cnt <= eff_cycles(t_gap) - TW'(1);
        end else cnt <= cnt - TW'(1);
        ST_GAP: if (cnt_zero) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - TW'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cle   = active && (kind_q == BK_CMD);
  assign ale   = active && (kind_q == BK_ADDR);
  assign dq_oe = active && (kind_q != BK_RD);
  assign dq_o  = byte_q;
  assign we_n  = !((st == ST_LOW) && (kind_q != BK_RD));
  assign re_n  = !((st == ST_LOW) && (kind_q == BK_RD));

  a_r11_drive_before_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(dq_oe));
  a_r6_sample_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!re_n));
  a_r8_done_from_gap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == ST_GAP));
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int TIMEOUT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   ctl,
  input  logic [31:0]   col,
  input  logic [31:0]   row,
  input  logic [31:0]   data,
  input  logic [7:0]    cfg,
  input  logic [TW-1:0] t_busy,
  input  logic          rdy,
  input  logic          str_idle,
  input  logic          str_done,
  input  logic          rd_valid,
  output logic          go,
  output kind_t         kind,
  output logic [7:0]    byte_out,
  output logic          rd_we,
  output logic [1:0]    rd_idx,
  output logic          done,
  output logic          err_set
);
  localparam int TCW = $clog2(TIMEOUT + 1);

  phase_t         ph_q;
  logic [1:0]     bidx;
  logic           issued;
  logic [TW-1:0]  wcnt;
  logic [TCW-1:0] tcnt;
  logic           byte_ph;
  logic [1:0]     last;

  assign byte_ph = (ph_q == PH_CMD0) || (ph_q == PH_COL) || (ph_q == PH_ROW) ||
                   (ph_q == PH_CMD1) || (ph_q == PH_DATA);
  assign last = phase_last(ph_q, ctl, cfg);
  assign go   = byte_ph && !issued && str_idle;

  always_comb begin
    kind     = BK_CMD;
    byte_out = '0;
    case (ph_q)
      PH_CMD0: byte_out = ctl[7:0];
      PH_CMD1: byte_out = ctl[15:8];
      PH_COL:  begin kind = BK_ADDR; byte_out = byte_of(col, bidx); end
      PH_ROW:  begin kind = BK_ADDR; byte_out = byte_of(row, bidx); end
      PH_DATA: begin
        kind     = ctl[B_WR] ? BK_WR : BK_RD;
        byte_out = byte_of(data, bidx);
      end
      default: ;
    endcase
  end

  assign rd_we  = rd_valid && (ph_q == PH_DATA);
  assign rd_idx = bidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      bidx    <= '0;
      issued  <= 1'b0;
      wcnt    <= '0;
      tcnt    <= '0;
      done    <= 1'b0;
      err_set <= 1'b0;
    end else begin
      done    <= 1'b0;
      err_set <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (start) begin
          ph_q   <= phase_after(PH_IDLE, ctl);
          bidx   <= '0;
          issued <= 1'b0;
        end
      end else if (byte_ph) begin
        if (go) issued <= 1'b1;
        if (str_done) begin
          issued <= 1'b0;
          wcnt   <= eff_cycles(t_busy) - TW'(1);
          if (bidx == last) begin
            ph_q <= phase_after(ph_q, ctl);
            bidx <= '0;
          end else bidx <= bidx + 2'd1;
        end
      end else begin
        case (ph_q)
          PH_WAIT: if (wcnt == '0) begin
            ph_q <= PH_POLL;
            tcnt <= '0;
          end else wcnt <= wcnt - TW'(1);
          PH_POLL: if (rdy) ph_q <= phase_after(PH_POLL, ctl);
          else if (tcnt == TCW'(TIMEOUT - 1)) begin
            err_set <= 1'b1;
            ph_q    <= PH_END;
          end else tcnt <= tcnt + TCW'(1);
          PH_END: begin
            done <= 1'b1;
            ph_q <= PH_IDLE;
          end
          default: ph_q <= PH_IDLE;
        endcase
      end
    end
  end

  a_r2_phase_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> (ph_q >= $past(ph_q)));
  a_r10_err_from_poll: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> ($past(ph_q) == PH_POLL && ph_q == PH_END));
  a_r9_data_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_POLL && ph_q == PH_DATA) |-> $past(rdy));
endmodule

// File: rtl/nand_cmd_engine.sv
module nand_cmd_engine
  import nfc_pkg::*;
#(
  parameter int TIMEOUT = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb_n
);
  logic [31:0] ctl_q, col_q, row_q, data_q, tim_q;
  logic [7:0]  cfg_q;
  logic        err_q, ce_low, start_q;
  logic [1:0]  rb_sync;
  logic        busy, start_now;
  logic        go, str_idle, str_done, rd_valid, rd_we, seq_done, err_set;
  kind_t       kind;
  logic [7:0]  byte_out, rd_byte;
  logic [1:0]  rd_idx;

  assign busy      = ctl_q[B_START];
  assign start_now = host_we && !busy && (host_addr == 3'd0) && host_wdata[B_START];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; col_q <= '0; row_q <= '0; data_q <= '0; tim_q <= '0;
      cfg_q <= '0; err_q <= 1'b0; ce_low <= 1'b0; start_q <= 1'b0;
      rb_sync <= '0;
    end else begin
      rb_sync <= {rb_sync[0], nand_rb_n};
      start_q <= start_now;
      if (host_we && !busy) begin
        case (host_addr)
          3'd0: ctl_q  <= host_wdata;
          3'd1: col_q  <= host_wdata;
          3'd2: row_q  <= host_wdata;
          3'd3: data_q <= host_wdata;
          3'd4: cfg_q  <= host_wdata[7:0];
          3'd5: tim_q  <= host_wdata;
          default: ;
        endcase
      end
      if (start_now) begin
        err_q  <= 1'b0;
        ce_low <= 1'b1;
        if (host_wdata[B_RD] && !host_wdata[B_WR]) data_q <= '0;
      end
      if (rd_we) data_q[8*rd_idx +: 8] <= rd_byte;
      if (err_set) err_q <= 1'b1;
      if (seq_done) begin
        ctl_q[B_START] <= 1'b0;
        ce_low         <= ctl_q[B_HOLD];
      end
    end
  end

  always_comb begin
    case (host_addr)
      3'd0: host_rdata = {ctl_q[31:28], err_q, rb_sync[1], ctl_q[25:0]};
      3'd1: host_rdata = col_q;
      3'd2: host_rdata = row_q;
      3'd3: host_rdata = data_q;
      3'd4: host_rdata = {24'd0, cfg_q};
      3'd5: host_rdata = tim_q;
      default: host_rdata = '0;
    endcase
  end

  assign nand_ce_n = !ce_low;

  nfc_seq #(.TIMEOUT(TIMEOUT)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start_q), .ctl(ctl_q), .col(col_q),
    .row(row_q), .data(data_q), .cfg(cfg_q), .t_busy(tim_q[29:24]),
    .rdy(rb_sync[1]), .str_idle(str_idle), .str_done(str_done),
    .rd_valid(rd_valid), .go(go), .kind(kind), .byte_out(byte_out),
    .rd_we(rd_we), .rd_idx(rd_idx), .done(seq_done), .err_set(err_set)
  );

  nfc_strobe strobe_i (
    .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .byte_in(byte_out),
    .t_setup(tim_q[17:12]), .t_low(tim_q[5:0]), .t_hold(tim_q[23:18]),
    .t_gap(tim_q[11:6]), .dq_i(nand_dq_i), .idle(str_idle), .done(str_done),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
  );

  a_r1_done_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !ctl_q[B_START]);
  a_r1_busy_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && !rd_we) |=> ($stable(col_q) && $stable(data_q) && $stable(tim_q)));
  a_r7_ce_low_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_now) |-> !nand_ce_n);
  a_r7_ce_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (nand_ce_n == !$past(ctl_q[B_HOLD])));
  a_r11_strobe_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> (busy && !nand_ce_n));
endmodule

// File: tb/nand_cmd_engine_tb_top.sv
module nand_cmd_engine_tb_top;
  localparam int TO = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb_n = 1'b1;

  int total = 0, bad = 0;
  logic [9:0] log_q [64];
  int log_n = 0;
  logic [9:0] exp_q [64];
  int exp_n;
  int rd_n = 0;
  int busy_len = 0, bcnt = 0;
  bit busy_go = 0;
  int we_low = 0, re_low = 0, cyc = 0;
  logic [31:0] col_v, row_v, data_v, tim_v;
  logic [7:0]  cfg_v;

  always #4 clk = ~clk;

  nand_cmd_engine #(.TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
  );

  function automatic logic [7:0] rd_val(input int n);
    return 8'((n * 37 + 5) & 255);
  endfunction

  always @(posedge nand_we_n) begin
    if (nand_ce_n === 1'b0 && log_n < 64) begin
      log_q[log_n] = {nand_cle, nand_ale, nand_dq_o};
      log_n++;
      if (nand_cle && busy_len > 0) busy_go = 1;
    end
  end

  always @(negedge nand_re_n) begin
    nand_dq_i = rd_val(rd_n);
    rd_n++;
  end

  always @(negedge clk) begin
    cyc++;
    if (nand_we_n === 1'b0) we_low++;
    if (nand_re_n === 1'b0) re_low++;
    if (busy_go) begin busy_go = 0; bcnt = busy_len; end
    if (bcnt > 0) begin nand_rb_n = 1'b0; bcnt--; end
    else nand_rb_n = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic setup_regs(input logic [31:0] c, input logic [31:0] r,
                            input logic [31:0] d, input logic [7:0] f,
                            input logic [31:0] t);
    col_v = c; row_v = r; data_v = d; cfg_v = f; tim_v = t;
    wr(3'd1, c); wr(3'd2, r); wr(3'd3, d); wr(3'd4, {24'd0, f}); wr(3'd5, t);
  endtask

  task automatic build_exp(input logic [31:0] w);
    exp_n = 0;
    if (w[16]) begin exp_q[exp_n] = {2'b10, w[7:0]}; exp_n++; end
    if (w[24]) begin exp_q[exp_n] = {2'b01, col_v[7:0]}; exp_n++; end
    else begin
      if (w[17]) for (int k = 0; k <= int'(cfg_v[5:4]); k++) begin
        exp_q[exp_n] = {2'b01, col_v[8*k +: 8]}; exp_n++;
      end
      if (w[18]) for (int k = 0; k <= int'(cfg_v[7:6]); k++) begin
        exp_q[exp_n] = {2'b01, row_v[8*k +: 8]}; exp_n++;
      end
    end
    if (w[19]) begin exp_q[exp_n] = {2'b10, w[15:8]}; exp_n++; end
    if (w[21]) for (int k = 0; k <= int'(w[29:28]); k++) begin
      exp_q[exp_n] = {2'b00, data_v[8*k +: 8]}; exp_n++;
    end
  endtask

  task automatic run_op(input logic [31:0] w, input bit expect_err, output int n0);
    logic [31:0] v;
    int guard;
    log_n = 0; we_low = 0; re_low = 0; n0 = rd_n;
    build_exp(w);
    wr(3'd0, w | 32'h8000_0000);
    cyc = 0;
    guard = 0;
    v = 32'hFFFF_FFFF;
    while (v[31] && guard < 20000) begin rd(3'd0, v); guard++; end
    chk(!v[31], "R1 start clears", v, 0);
    chk(v[27] == expect_err, "R10 error flag", 32'(v[27]), 32'(expect_err));
    chk(log_n == exp_n, "R2 bus byte count", log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++)
      chk(log_q[k] == exp_q[k], "R2 R3 R4 R5 R11 bus byte", 32'(log_q[k]), 32'(exp_q[k]));
  endtask

  task automatic check_data(input logic [31:0] w, input int n0, input bit timed_out);
    logic [31:0] v, e;
    int cnt;
    rd(3'd3, v);
    cnt = int'(w[29:28]) + 1;
    if (!w[21] && w[20] && !timed_out) begin
      e = '0;
      for (int k = 0; k < cnt; k++) e[8*k +: 8] = rd_val(n0 + k);
      chk(rd_n - n0 == cnt, "R6 read count", rd_n - n0, cnt);
    end else begin
      e = (!w[21] && w[20]) ? 32'd0 : data_v;
      chk(rd_n == n0, "R5 no read strobes", rd_n - n0, 0);
    end
    chk(v == e, "R6 data register", v, e);
    data_v = v;
  endtask

  initial begin
    #(8 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    int n0;
    void'($urandom(32'h1234_5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v);
    chk(!v[31] && !v[27], "R1 reset control", v, 0);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R7 reset pins",
        {27'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'h1C);

    setup_regs(32'h4433_2211, 32'h8877_6655, 32'hDDCC_BBAA, 8'b10_01_0010, 32'd5);
    w = 32'h0001_0090;
    run_op(w, 0, n0);
    chk(we_low == 5, "R8 we low width", we_low, 5);

    setup_regs(col_v, row_v, data_v, cfg_v, 32'h0000_0000);
    run_op(w, 0, n0);
    chk(we_low == 1, "R8 zero field counts as one", we_low, 1);

    setup_regs(col_v, row_v, data_v, 8'b11_11_0010, 32'h0000_0003);
    w = 32'h3010_0000;
    run_op(w, 0, n0);
    check_data(w, n0, 0);
    chk(re_low == 12, "R8 re low width", re_low, 12);

    w = 32'h0107_0030 | 32'h0100_0000;
    run_op(w, 0, n0);

    w = 32'h7021_0080;
    run_op(w, 0, n0);
    @(negedge clk);
    chk(nand_ce_n == 1'b0, "R7 hold keeps CE low", nand_ce_n, 0);
    w = 32'h0030_0000;
    run_op(w, 0, n0);
    check_data(w, n0, 0);
    @(negedge clk);
    chk(nand_ce_n == 1'b1, "R7 CE released", nand_ce_n, 1);

    setup_regs(col_v, row_v, data_v, 8'b00_01_0010, 32'h0000_3FFF);
    w = 32'h0003_00A5;
    build_exp(w);
    log_n = 0;
    wr(3'd0, w | 32'h8000_0000);
    wr(3'd1, 32'h0BAD_0BAD);
    wr(3'd0, 32'h8001_00EE);
    v = 32'hFFFF_FFFF;
    for (int g = 0; g < 20000 && v[31]; g++) rd(3'd0, v);
    chk(log_n == exp_n && log_q[0] == exp_q[0], "R1 writes ignored while busy",
        32'(log_q[0]), 32'(exp_q[0]));
    rd(3'd1, v);
    chk(v == col_v, "R1 column kept", v, col_v);

    setup_regs(col_v, row_v, data_v, cfg_v, 32'h0000_0000);
    busy_len = 40;
    w = 32'h1019_3011;
    run_op(w, 0, n0);
    check_data(w, n0, 0);
    chk(cyc >= 40, "R9 waits for ready", cyc, 40);

    busy_len = 60;
    w = 32'h0001_0070;
    run_op(w, 0, n0);
    rd(3'd0, v);
    chk(v[26] == 1'b0, "R9 ready bit low while busy", 32'(v[26]), 0);
    repeat (70) @(negedge clk);
    rd(3'd0, v);
    chk(v[26] == 1'b1, "R9 ready bit high", 32'(v[26]), 1);

    busy_len = 1000;
    w = 32'h0019_3000;
    run_op(w, 1, n0);
    check_data(w, n0, 1);
    repeat (1100) @(negedge clk);
    busy_len = 0;
    w = 32'h0001_00FF;
    run_op(w, 0, n0);

    for (int it = 0; it < 40; it++) begin
      logic [31:0] t;
      t = $urandom & 32'h03CF_3CF3;
      setup_regs($urandom, $urandom, $urandom, 8'($urandom), t);
      w = $urandom & 32'h313F_FFFF;
      if (($urandom % 5) != 0) w[24] = 1'b0;
      busy_len = $urandom % 12;
      run_op(w, 0, n0);
      check_data(w, n0, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule